// File: doc/BRIEF.md
# Block-Packing Write Buffer

This buffer sits between a requester that issues 32-bit word accesses and a memory port that accepts whole 16-byte block writes. Word writes that land in one aligned 16-byte block are gathered in a single open block, together with a per-byte enable mask. Memory sees one wide transfer per block instead of one narrow write per word. A processor port and an I/O bus-master port would each get their own instance.

The open block goes to memory in four cases. The first is when all sixteen bytes have been written. The second is when a write arrives for a different block. The third is when a read targets the open block. The fourth is on an explicit flush request or after a programmable number of idle cycles. The outgoing packet waits in a single output slot, so at most one packet is outstanding. Reads do not pass through the buffer. A read is forwarded on a separate read port only when neither the open block nor the outstanding packet holds data for its block, so a read can never fetch memory contents that are older than a buffered write.

Top module: `wpb_write_packer`

## Requirements
- R1: After reset no packet and no read are presented (`mem_valid`=0, `rd_valid`=0). A write is ready at once (`in_ready`=1 when `in_write`=1).
- R2: A write accepted into the open block with the same block address (`in_addr[31:4]`) starts no memory transfer. `mem_valid` stays 0 in the following cycle.
- R3: Once all 16 bytes of the open block are enabled, the block is presented the next cycle with `mem_be`=16'hFFFF and `mem_addr` equal to the block base (low 4 bits zero).
- R4: Byte `i` of a write with word index `k` = `in_addr[3:2]` lands in packet byte `4*k+i`, which is `mem_data[32*k+8*i +: 8]` with enable `mem_be[4*k+i]`. Bytes never written carry enable 0 and data 0.
- R5: A write to another block pushes the open block into the output slot. If the slot is empty, the write is accepted in the same cycle and opens a new block. If the slot is occupied, `in_ready` stays 0 until the slot empties.
- R6: A read whose block matches the open block or the outstanding packet is held (`rd_valid`=0, `in_ready`=0). The open block is drained, and the read proceeds only after the packet is taken by memory.
- R7: A read with no matching buffered data passes straight through: `rd_valid`=`in_valid`, `rd_addr`=`in_addr`, `in_ready`=`rd_ready`.
- R8: A one-cycle `flush_req` forces the open partial block out as a packet. When no block is open, `flush_req` has no effect.
- R9: An open block that accepts no write for `IDLE_CYCLES` cycles is drained. Its packet first appears `IDLE_CYCLES`+1 clock edges after the edge that accepted the last write.
- R10: While `mem_valid`=1 and `mem_ready`=0, `mem_addr`, `mem_data` and `mem_be` hold their values. No second packet is formed.
- R11: A later write to a byte already held in the open block replaces that byte.
- R12: If `flush_req` and a write that merges into the open block fall in the same cycle, the write is included in the flushed packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | 32 | Byte address of the word |
| in_wdata | input | 32 | Write data |
| in_be | input | 4 | Write byte enables |
| flush_req | input | 1 | Force the open block out |
| rd_valid | output | 1 | Read forwarded to memory |
| rd_ready | input | 1 | Memory takes the read |
| rd_addr | output | 32 | Forwarded read address |
| mem_valid | output | 1 | Block packet present |
| mem_ready | input | 1 | Memory takes the packet |
| mem_addr | output | 32 | Block base address |
| mem_data | output | 128 | Block data |
| mem_be | output | 16 | Per-byte enables of the packet |

## Verification
Three pairs of events can fall in the same cycle, and each is provoked on purpose. The first pair is a flush request and a write merging into the open block. The bench raises both in one cycle and judges the pairing by the packet's byte mask, which must include the merged word. The second pair is a write that misses the open block and the drain of that block. Here the bench measures that the miss is accepted with no stall while the slot is free. It then keeps the slot occupied and confirms that the next miss is held back. The third pair is a read that hits pending data. The bench checks the read stays hidden through both the drain and the memory handshake.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [WORD_BYTES-1:0] wbe_t;

    // Why the open block leaves for the output slot, in priority order
    typedef enum logic [2:0] {
        DR_NONE,
        DR_FULL,
        DR_MISS,
        DR_READ,
        DR_FLUSH,
        DR_IDLE
    } drain_cause_e;

    // Byte-wise overlay of a new word on an old one
    function automatic word_t merge_word(word_t old_w, word_t new_w, wbe_t be);
        word_t r;
        r = old_w;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wpb_block_store.sv
module wpb_block_store
    import wpb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int OFF_W    = $clog2(BLK_WORDS * WORD_BYTES),
    localparam int TAG_W    = ADDR_W - OFF_W,
    localparam int WIDX_W   = $clog2(BLK_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_new,
    input  logic                         merge,
    input  logic                         clear,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [WIDX_W-1:0]            wr_widx,
    input  word_t                        wr_data,
    input  wbe_t                         wr_be,
    output logic                         open_v,
    output logic [TAG_W-1:0]             open_tag,
    output logic [BLK_WORDS*WORD_W-1:0]  open_data,
    output logic [BLK_WORDS*WORD_BYTES-1:0] open_mask,
    output logic                         open_full
);

    word_t data_q [BLK_WORDS];
    wbe_t  mask_q [BLK_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_v   <= 1'b0;
            open_tag <= '0;
        end else if (load_new) begin
            open_v   <= 1'b1;
            open_tag <= wr_tag;
        end else if (clear) begin
            open_v   <= 1'b0;
        end
    end

    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_lane
        logic sel;
        assign sel = (wr_widx == WIDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[w] <= '0;
                mask_q[w] <= '0;
            end else if (load_new) begin
                data_q[w] <= sel ? merge_word('0, wr_data, wr_be) : '0;
                mask_q[w] <= sel ? wr_be : '0;
            end else if (merge && sel) begin
                data_q[w] <= merge_word(data_q[w], wr_data, wr_be);
                mask_q[w] <= mask_q[w] | wr_be;
            end
        end

        assign open_data[w*WORD_W +: WORD_W]         = data_q[w];
        assign open_mask[w*WORD_BYTES +: WORD_BYTES] = mask_q[w];
    end

    assign open_full = open_v && (&open_mask);

    // R11: a merge keeps every byte already enabled
    a_r11_mask_grows: assert property (@(posedge clk) disable iff (rst)
        (merge && !load_new) |=> ((open_mask & $past(open_mask)) == $past(open_mask)));

endmodule

// File: rtl/wpb_idle_timer.sv
module wpb_idle_timer #(
    parameter int IDLE_CYCLES = 8,
    localparam int CNT_W      = $clog2(IDLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    output logic expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || kick || !active) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(IDLE_CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt == CNT_W'(IDLE_CYCLES));

    // R9: the counter saturates at the limit
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(IDLE_CYCLES));

endmodule

// File: rtl/wpb_packet_slot.sv
module wpb_packet_slot
    import wpb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int OFF_W    = $clog2(BLK_WORDS * WORD_BYTES),
    localparam int TAG_W    = ADDR_W - OFF_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load,
    input  logic [TAG_W-1:0]                ld_tag,
    input  logic [BLK_WORDS*WORD_W-1:0]     ld_data,
    input  logic [BLK_WORDS*WORD_BYTES-1:0] ld_mask,
    input  logic                            mem_ready,
    output logic                            mem_valid,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [BLK_WORDS*WORD_W-1:0]     mem_data,
    output logic [BLK_WORDS*WORD_BYTES-1:0] mem_be
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            mem_be    <= '0;
        end else if (load) begin
            mem_valid <= 1'b1;
            mem_addr  <= {ld_tag, {OFF_W{1'b0}}};
            mem_data  <= ld_data;
            mem_be    <= ld_mask;
        end else if (mem_valid && mem_ready) begin
            mem_valid <= 1'b0;
        end
    end

    // R10: packet held steady while memory stalls
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    // R10: a new packet only enters an empty slot
    a_r10_single: assert property (@(posedge clk) disable iff (rst)
        load |-> !mem_valid);

endmodule

// File: rtl/wpb_write_packer.sv
module wpb_write_packer
    import wpb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLK_WORDS   = 4,
    parameter int IDLE_CYCLES = 8,
    localparam int OFF_W      = $clog2(BLK_WORDS * WORD_BYTES),
    localparam int TAG_W      = ADDR_W - OFF_W,
    localparam int WIDX_W     = $clog2(BLK_WORDS),
    localparam int BLK_W      = BLK_WORDS * WORD_W,
    localparam int BLK_B      = BLK_WORDS * WORD_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_write,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [WORD_W-1:0]     in_wdata,
    input  logic [WORD_BYTES-1:0] in_be,
    input  logic                  flush_req,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [BLK_W-1:0]      mem_data,
    output logic [BLK_B-1:0]      mem_be
);

    logic [TAG_W-1:0]  in_tag;
    logic [WIDX_W-1:0] in_widx;
    logic              open_v, open_full, idle_exp, flush_pend;
    logic [TAG_W-1:0]  open_tag;
    logic [BLK_W-1:0]  open_data;
    logic [BLK_B-1:0]  open_mask;
    logic              is_wr, is_rd, hit_open, hit_pkt;
    logic              drain_req, drain, wr_ready, rd_ok;
    logic              wr_acc, load_new, merge, clear;
    drain_cause_e      cause;

    assign in_tag  = in_addr[ADDR_W-1:OFF_W];
    assign in_widx = in_addr[OFF_W-1:2];

    assign is_wr    = in_valid && in_write;
    assign is_rd    = in_valid && !in_write;
    assign hit_open = open_v && (in_tag == open_tag);
    assign hit_pkt  = mem_valid && (in_tag == mem_addr[ADDR_W-1:OFF_W]);

    always_comb begin
        cause = DR_NONE;
        if (open_v) begin
            if (open_full)                cause = DR_FULL;
            else if (is_wr && !hit_open)  cause = DR_MISS;
            else if (is_rd && hit_open)   cause = DR_READ;
            else if (flush_pend)          cause = DR_FLUSH;
            else if (idle_exp)            cause = DR_IDLE;
        end
    end

    assign drain_req = (cause != DR_NONE);
    assign drain     = drain_req && !mem_valid;

    // write: open fresh, merge when nothing pending, or replace on a miss drain
    assign wr_ready = !open_v || (hit_open && !drain_req) || (!hit_open && drain);
    assign rd_ok    = !hit_open && !hit_pkt;

    assign in_ready = in_write ? wr_ready : (rd_ok && rd_ready);
    assign rd_valid = is_rd && rd_ok;
    assign rd_addr  = in_addr;

    assign wr_acc   = is_wr && wr_ready;
    assign load_new = wr_acc && !hit_open;
    assign merge    = wr_acc && hit_open;
    assign clear    = drain && !load_new;

    always_ff @(posedge clk) begin
        if (rst) flush_pend <= 1'b0;
        else     flush_pend <= open_v && !drain && (flush_pend || flush_req);
    end

    wpb_block_store #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .load_new (load_new),
        .merge    (merge),
        .clear    (clear),
        .wr_tag   (in_tag),
        .wr_widx  (in_widx),
        .wr_data  (in_wdata),
        .wr_be    (in_be),
        .open_v   (open_v),
        .open_tag (open_tag),
        .open_data(open_data),
        .open_mask(open_mask),
        .open_full(open_full)
    );

    wpb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (open_v),
        .kick   (wr_acc),
        .expired(idle_exp)
    );

    wpb_packet_slot #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (drain),
        .ld_tag   (open_tag),
        .ld_data  (open_data),
        .ld_mask  (open_mask),
        .mem_ready(mem_ready),
        .mem_valid(mem_valid),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_be   (mem_be)
    );

    // R2: a merging write leaves memory idle
    a_r2_merge_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_write && open_v && in_tag == open_tag && !mem_valid)
            |=> !mem_valid);

    // R3: a full block reaches the slot with every byte enabled
    a_r3_full_emits: assert property (@(posedge clk) disable iff (rst)
        (open_full && !mem_valid) |=> (mem_valid && mem_be == '1));

    // R5: an accepted miss pushes the old block out
    a_r5_miss_emits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_write && open_v && in_tag != open_tag)
            |=> (mem_valid && mem_addr[ADDR_W-1:OFF_W] == $past(open_tag)));

    // R6: no forwarded read overlaps buffered data
    a_r6_no_stale_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !(mem_valid && mem_addr[ADDR_W-1:OFF_W] == rd_addr[ADDR_W-1:OFF_W])
                  && !(open_v && open_tag == rd_addr[ADDR_W-1:OFF_W]));

endmodule

// File: tb/wpb_write_packer_tb.sv
module wpb_write_packer_tb;

    localparam int IDLE = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_write, flush_req, rd_ready, mem_ready;
    logic         in_ready, rd_valid, mem_valid;
    logic [31:0]  in_addr, in_wdata, rd_addr, mem_addr;
    logic [3:0]   in_be;
    logic [127:0] mem_data;
    logic [15:0]  mem_be;

    int checks = 0;
    int errors = 0;
    int pkt_cnt = 0;
    logic [31:0]  cap_addr [8];
    logic [127:0] cap_data [8];
    logic [15:0]  cap_be   [8];

    always #2 clk = ~clk;

    wpb_write_packer #(.IDLE_CYCLES(IDLE)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
        .in_addr(in_addr), .in_wdata(in_wdata), .in_be(in_be),
        .flush_req(flush_req),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be)
    );

    // packet capture: values read here are the ones before the edge
    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            cap_addr[pkt_cnt % 8] = mem_addr;
            cap_data[pkt_cnt % 8] = mem_data;
            cap_be[pkt_cnt % 8]   = mem_be;
            pkt_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, output int stalls);
        @(negedge clk);
        in_valid = 1'b1; in_write = w; in_addr = a; in_wdata = d; in_be = b;
        stalls = 0;
        #1;
        while (!in_ready && stalls < 100) begin
            @(negedge clk); #1; stalls++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
    endtask

    task automatic wait_pkt(input int target);
        int n = 0;
        while (pkt_cnt < target && n < 60) begin
            @(negedge clk); n++;
        end
    endtask

    function automatic logic [127:0] place(input int off, input logic [31:0] d,
                                           input logic [3:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 4; i++)
            if (b[i]) r[off*32 + 8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    initial begin
        int st, base, k;
        logic [31:0] a0;
        in_valid = 0; in_write = 1; in_addr = 0; in_wdata = 0; in_be = 0;
        flush_req = 0; rd_ready = 1; mem_ready = 1; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk(!mem_valid && !rd_valid, "R1 idle outputs", {mem_valid, rd_valid}, 0);
        chk(in_ready, "R1 write ready", in_ready, 1);

        // R4 sweep: every non-empty byte mask at every word slot
        for (int off = 0; off < 4; off++) begin
            for (int b = 1; b < 16; b++) begin
                logic [31:0] d = 32'hA1B2C3D4 ^ (off * 32'h01010101) ^ b;
                base = pkt_cnt;
                send(1, 32'h0000_1000 + off*4, d, 4'(b), st);
                pulse_flush();
                wait_pkt(base + 1);
                chk(pkt_cnt == base + 1, "R8 flush emits", pkt_cnt, base + 1);
                chk(cap_be[base % 8] == (16'(b) << (4*off)) &&
                    cap_data[base % 8] == place(off, d, 4'(b)) &&
                    cap_addr[base % 8] == 32'h1000,
                    "R4 lane placement", cap_data[base % 8], place(off, d, 4'(b)));
            end
        end

        // R2 / R3: four word writes fill a block, one packet
        base = pkt_cnt;
        for (int w = 0; w < 3; w++) send(1, 32'h2004_0030 + w*4, 32'h11111111 * (w+1), 4'hF, st);
        repeat (2) @(negedge clk);
        chk(pkt_cnt == base && !mem_valid, "R2 merge no access", pkt_cnt, base);
        send(1, 32'h2004_003C, 32'h44444444, 4'hF, st);
        wait_pkt(base + 1);
        chk(cap_be[base % 8] == 16'hFFFF && cap_addr[base % 8] == 32'h2004_0030,
            "R3 full block", {cap_addr[base % 8], cap_be[base % 8]}, {32'h2004_0030, 16'hFFFF});
        chk(cap_data[base % 8] == {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111},
            "R3 full data", cap_data[base % 8], 0);

        // R11: overwrite of bytes already held
        base = pkt_cnt;
        send(1, 32'h0000_3004, 32'hAABBCCDD, 4'hF, st);
        send(1, 32'h0000_3004, 32'h00001122, 4'h3, st);
        pulse_flush();
        wait_pkt(base + 1);
        chk(cap_data[base % 8] == {64'h0, 32'hAABB1122, 32'h0} && cap_be[base % 8] == 16'h00F0,
            "R11 last write wins", cap_data[base % 8], {64'h0, 32'hAABB1122, 32'h0});

        // R5: miss with empty slot is taken without a stall
        base = pkt_cnt;
        send(1, 32'h0000_4000, 32'h01020304, 4'hF, st);
        send(1, 32'h0000_5008, 32'h05060708, 4'hF, st);
        chk(st == 0, "R5 miss no stall", st, 0);
        wait_pkt(base + 1);
        chk(cap_addr[base % 8] == 32'h4000 && cap_be[base % 8] == 16'h000F,
            "R5 old block emitted", cap_addr[base % 8], 32'h4000);
        pulse_flush();
        wait_pkt(base + 2);
        chk(cap_addr[(base+1) % 8] == 32'h5000 && cap_be[(base+1) % 8] == 16'h0F00,
            "R5 new block opened", cap_addr[(base+1) % 8], 32'h5000);

        // R5 / R10: miss held while slot busy
        base = pkt_cnt;
        mem_ready = 0;
        send(1, 32'h0000_6000, 32'hCAFE0001, 4'hF, st);
        send(1, 32'h0000_7000, 32'hCAFE0002, 4'hF, st);
        @(negedge clk);
        in_valid = 1; in_write = 1; in_addr = 32'h0000_8000; in_wdata = 32'hCAFE0003; in_be = 4'hF;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(!in_ready, "R5 miss stalls on busy slot", in_ready, 0);
            chk(mem_valid && mem_addr == 32'h6000 && mem_be == 16'h000F,
                "R10 packet held", mem_addr, 32'h6000);
            @(negedge clk);
        end
        mem_ready = 1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1; in_valid = 0;
        pulse_flush();
        wait_pkt(base + 3);
        chk(cap_addr[base % 8] == 32'h6000 && cap_addr[(base+1) % 8] == 32'h7000 &&
            cap_addr[(base+2) % 8] == 32'h8000, "R10 packet order",
            cap_addr[(base+2) % 8], 32'h8000);

        // R6: read hitting open block waits for drain and handshake
        base = pkt_cnt;
        mem_ready = 0;
        send(1, 32'h0000_9000, 32'h12345678, 4'hF, st);
        @(negedge clk);
        in_valid = 1; in_write = 0; in_addr = 32'h0000_9008;
        #1;
        chk(!rd_valid && !in_ready, "R6 read held on open block", rd_valid, 0);
        @(negedge clk); #1;
        chk(mem_valid && mem_addr == 32'h9000, "R6 block drained", mem_addr, 32'h9000);
        chk(!rd_valid, "R6 read held on packet", rd_valid, 0);
        mem_ready = 1;
        @(negedge clk); #1;
        chk(rd_valid && in_ready && rd_addr == 32'h9008, "R6 read released", rd_addr, 32'h9008);
        @(posedge clk); #1; in_valid = 0;
        chk(pkt_cnt == base + 1, "R6 one packet", pkt_cnt, base + 1);

        // R7: unrelated read passes through
        @(negedge clk);
        in_valid = 1; in_write = 0; in_addr = 32'h0000_A104; rd_ready = 0;
        #1;
        chk(rd_valid && rd_addr == 32'hA104 && !in_ready, "R7 pass, not ready",
            {rd_valid, in_ready}, 2'b10);
        rd_ready = 1;
        #1;
        chk(in_ready, "R7 pass, ready", in_ready, 1);
        @(posedge clk); #1; in_valid = 0;

        // R8: flush with nothing open
        base = pkt_cnt;
        pulse_flush();
        repeat (4) @(negedge clk);
        chk(pkt_cnt == base && !mem_valid, "R8 empty flush ignored", pkt_cnt, base);

        // R9: writes closer than the limit keep the block, then timeout
        base = pkt_cnt;
        for (int w = 0; w < 3; w++) begin
            send(1, 32'h0000_B000 + w*4, 32'h0, 4'h1, st);
            repeat (IDLE - 3) @(negedge clk);
        end
        chk(pkt_cnt == base && !mem_valid, "R9 kept alive", pkt_cnt, base);
        send(1, 32'h0000_B00C, 32'h0, 4'h1, st);
        k = 0;
        while (!mem_valid && k < 50) begin @(posedge clk); #1; k++; end
        chk(k == IDLE + 1, "R9 idle drain timing", k, IDLE + 1);
        wait_pkt(base + 1);
        chk(cap_be[base % 8] == 16'h1111, "R9 idle packet", cap_be[base % 8], 16'h1111);

        // R12: flush coinciding with a merging write
        base = pkt_cnt;
        send(1, 32'h0000_C000, 32'h0000_00EE, 4'h1, st);
        @(negedge clk);
        in_valid = 1; in_write = 1; in_addr = 32'h0000_C004; in_wdata = 32'h77; in_be = 4'h1;
        flush_req = 1;
        #1;
        chk(in_ready, "R12 write accepted with flush", in_ready, 1);
        @(posedge clk); #1; in_valid = 0; flush_req = 0;
        wait_pkt(base + 1);
        a0 = 32'h0;
        chk(cap_be[base % 8] == 16'h0011 && cap_data[base % 8][39:32] == 8'h77,
            "R12 write in flushed packet", cap_be[base % 8], 16'h0011);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule